// File: doc/BRIEF.md
# Programmed I/O Card Control Section

This block is the control section that each card on a 16-bit minicomputer I/O backplane carries. The processor runs every I/O instruction through one-clock phases T2 to T6 and raises strobes on a shared signal vector. The block keeps a control flip-flop, a two-stage flag (a flag buffer that feeds the flag) and an interrupt-request flip-flop. From these it returns the skip, priority-low, interrupt-request and service-request lines. It also holds a data register that output strobes load and input strobes drive onto the data bus.

A card acts on its own strobes only when the select code on the bus matches its parameter. The reset, preset, enable-flag and set-interrupt strobes reach every card, whatever the select code. The peripheral reports completion on a device-done input. That input fills only the flag buffer. The flag follows on the next enable-flag phase, so a completion never disturbs an instruction that is already running.

Top module: `pio_card_ctrl`

## Requirements
- R1: After a synchronous reset, control, flag buffer, flag, interrupt request and the data register are all zero. So srq=0, irq=0, prl=1, skip=0 and dout=0.
- R2: Card-specific strobes act only when io_sc equals CARD_SC (valid values 2 to 63). A strobe sent under any other select code changes nothing and returns no skip and no data.
- R3: Phase bit 0..4 means T2..T6. Set-control (strobe bit 6) and clear-control (bit 7) act in T4 when dma_cyc=0 and in T3 when dma_cyc=1. They are ignored in any other phase. Clear wins when both arrive together.
- R4: Set-flag (bit 8) in T3 sets both the flag buffer and the flag. Clear-flag (bit 9) in T4 clears both. Either strobe is ignored in any other phase.
- R5: dev_done sets only the flag buffer. Enable-flag (bit 3) in T2 sets the flag when the buffer is set and never clears the flag.
- R6: Skip-if-flag-set (bit 10) raises skip when the flag is 1. Skip-if-flag-clear (bit 11) raises skip when the flag is 0. Skip can be raised only in T3, T4 or T5, and it is combinational within that cycle.
- R7: A clear-flag that arrives in the same cycle as a skip test is applied after the test. The skip reflects the flag from before the clear.
- R8: Set-interrupt-request (bit 4) in T5 sets irq only when control, flag and flag buffer are all 1.
- R9: Enable-flag in T2 clears irq.
- R10: Interrupt acknowledge (bit 5) in T6 clears the flag buffer and leaves the flag and irq as they are.
- R11: srq equals the flag. prl is 0 exactly when control and flag are both 1.
- R12: I/O preset (bit 1) sets the flag buffer and the flag and clears irq. Control reset (bit 2) clears control only. Power-on (bit 0) clears the data register. All three act in any phase and ignore the select code.
- R13: Output-data (bit 12) in T3 or T4 loads din into the data register. Input-data (bit 13) in T4 or T5 drives the register onto dout. In every other case dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 5 | One-hot phase, bit 0 = T2 ... bit 4 = T6 |
| strobe | input | 14 | Backplane signal strobes, bit map in R3 to R13 |
| io_sc | input | 6 | Select code on the bus |
| dma_cyc | input | 1 | Current cycle belongs to a DMA transfer |
| dev_done | input | 1 | Peripheral completion, sets flag buffer |
| din | input | 16 | Data bus toward the card |
| dout | output | 16 | Data bus from the card, zero when not read |
| skip | output | 1 | Skip indication for flag tests |
| prl | output | 1 | Priority-low, enables lower-priority cards |
| irq | output | 1 | Interrupt request |
| srq | output | 1 | Service request |

## Verification
The hardest state to reach from the ports is a set flag buffer next to a clear flag. Set-flag and clear-flag always move both stages together, so only a device completion can separate them. The stimulus clears the flag, pulses dev_done and shows that srq stays low. A later T2 enable-flag then raises srq, and a T5 set-interrupt strobe raises irq, which proves that the buffer held the bit. A second case that is hard to reach is a skip test and a clear-flag in the same T4 cycle. Here the skip is sampled inside that cycle and the flag on the next one.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NPH  = 5;
  localparam int NSIG = 14;

  // phase bit positions
  localparam int PH_T2 = 0;
  localparam int PH_T3 = 1;
  localparam int PH_T4 = 2;
  localparam int PH_T5 = 3;
  localparam int PH_T6 = 4;

  // strobe bit positions
  localparam int SG_PON = 0;
  localparam int SG_PRE = 1;
  localparam int SG_CRS = 2;
  localparam int SG_ENF = 3;
  localparam int SG_SIR = 4;
  localparam int SG_IAK = 5;
  localparam int SG_STC = 6;
  localparam int SG_CLC = 7;
  localparam int SG_STF = 8;
  localparam int SG_CLF = 9;
  localparam int SG_SFS = 10;
  localparam int SG_SFC = 11;
  localparam int SG_IOO = 12;
  localparam int SG_IOI = 13;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int SCW = 6,
  parameter logic [SCW-1:0] CARD_SC = 6'o12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPH-1:0]  phase,
  input  logic [NSIG-1:0] strobe,
  input  logic [SCW-1:0]  io_sc,
  input  logic            dma_cyc,
  input  logic            flg_q,
  output logic            a_pon,
  output logic            a_pre,
  output logic            a_crs,
  output logic            a_enf,
  output logic            a_sir,
  output logic            a_iak,
  output logic            a_stc,
  output logic            a_clc,
  output logic            a_stf,
  output logic            a_clf,
  output logic            a_ld,
  output logic            a_rd,
  output logic            skip
);
  logic sel, ctl_ph, skip_ph;

  always_comb begin
    sel     = (io_sc == CARD_SC);
    ctl_ph  = dma_cyc ? phase[PH_T3] : phase[PH_T4];
    skip_ph = phase[PH_T3] | phase[PH_T4] | phase[PH_T5];
    a_pon = strobe[SG_PON];
    a_pre = strobe[SG_PRE];
    a_crs = strobe[SG_CRS];
    a_enf = strobe[SG_ENF] & phase[PH_T2];
    a_sir = strobe[SG_SIR] & phase[PH_T5];
    a_iak = sel & strobe[SG_IAK] & phase[PH_T6];
    a_stc = sel & strobe[SG_STC] & ctl_ph;
    a_clc = sel & strobe[SG_CLC] & ctl_ph;
    a_stf = sel & strobe[SG_STF] & phase[PH_T3];
    a_clf = sel & strobe[SG_CLF] & phase[PH_T4];
    a_ld  = sel & strobe[SG_IOO] & (phase[PH_T3] | phase[PH_T4]);
    a_rd  = sel & strobe[SG_IOI] & (phase[PH_T4] | phase[PH_T5]);
    // the test reads the registered flag, so a clear in the same cycle lands afterwards
    skip  = sel & skip_ph &
            ((strobe[SG_SFS] & flg_q) | (strobe[SG_SFC] & ~flg_q));
  end

  p_skip_window_r6: assert property (@(posedge clk) disable iff (rst)
    skip |-> (phase[PH_T3] || phase[PH_T4] || phase[PH_T5]));
endmodule

// File: rtl/pio_flag_ctl.sv
module pio_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic a_pre,
  input  logic a_crs,
  input  logic a_enf,
  input  logic a_sir,
  input  logic a_iak,
  input  logic a_stc,
  input  logic a_clc,
  input  logic a_stf,
  input  logic a_clf,
  input  logic dev_done,
  output logic ctl_q,
  output logic flg_q,
  output logic irq_q
);
  logic buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= 1'b0;
      buf_q <= 1'b0;
      flg_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (a_crs || a_clc)  ctl_q <= 1'b0;
      else if (a_stc)      ctl_q <= 1'b1;

      if (a_pre || a_stf || dev_done) buf_q <= 1'b1;
      else if (a_clf || a_iak)        buf_q <= 1'b0;

      if (a_pre || a_stf)          flg_q <= 1'b1;
      else if (a_clf)              flg_q <= 1'b0;
      else if (a_enf && buf_q)     flg_q <= 1'b1;

      if (a_pre || a_enf)                          irq_q <= 1'b0;
      else if (a_sir && ctl_q && flg_q && buf_q)   irq_q <= 1'b1;
    end
  end

  p_clf_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (a_clf && !a_pre) |=> !flg_q);
  p_enf_drops_irq_r9: assert property (@(posedge clk) disable iff (rst)
    a_enf |=> !irq_q);
  p_iak_buf_r10: assert property (@(posedge clk) disable iff (rst)
    (a_iak && !a_pre && !a_stf && !dev_done) |=> !buf_q);
  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(a_sir));
endmodule

// File: rtl/pio_data_reg.sv
module pio_data_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld,
  input  logic          rd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (ld)    q <= din;
  end

  assign dout = rd ? q : '0;

  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!ld && !clr) |=> $stable(q));
endmodule

// File: rtl/pio_card_ctrl.sv
module pio_card_ctrl
  import pio_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SCW = 6,
  parameter logic [SCW-1:0] CARD_SC = 6'o12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPH-1:0]  phase,
  input  logic [NSIG-1:0] strobe,
  input  logic [SCW-1:0]  io_sc,
  input  logic            dma_cyc,
  input  logic            dev_done,
  input  logic [DW-1:0]   din,
  output logic [DW-1:0]   dout,
  output logic            skip,
  output logic            prl,
  output logic            irq,
  output logic            srq
);
  logic a_pon, a_pre, a_crs, a_enf, a_sir, a_iak;
  logic a_stc, a_clc, a_stf, a_clf, a_ld, a_rd;
  logic ctl_q, flg_q, irq_q;

  pio_decode #(.SCW(SCW), .CARD_SC(CARD_SC)) u_dec (
    .clk(clk), .rst(rst), .phase(phase), .strobe(strobe), .io_sc(io_sc),
    .dma_cyc(dma_cyc), .flg_q(flg_q),
    .a_pon(a_pon), .a_pre(a_pre), .a_crs(a_crs), .a_enf(a_enf),
    .a_sir(a_sir), .a_iak(a_iak), .a_stc(a_stc), .a_clc(a_clc),
    .a_stf(a_stf), .a_clf(a_clf), .a_ld(a_ld), .a_rd(a_rd), .skip(skip)
  );

  pio_flag_ctl u_flg (
    .clk(clk), .rst(rst), .a_pre(a_pre), .a_crs(a_crs), .a_enf(a_enf),
    .a_sir(a_sir), .a_iak(a_iak), .a_stc(a_stc), .a_clc(a_clc),
    .a_stf(a_stf), .a_clf(a_clf), .dev_done(dev_done),
    .ctl_q(ctl_q), .flg_q(flg_q), .irq_q(irq_q)
  );

  pio_data_reg #(.DW(DW)) u_dat (
    .clk(clk), .rst(rst), .clr(a_pon), .ld(a_ld), .rd(a_rd),
    .din(din), .dout(dout)
  );

  assign srq = flg_q;
  assign prl = ~(ctl_q & flg_q);
  assign irq = irq_q;

  p_prl_vs_srq_r11: assert property (@(posedge clk) disable iff (rst)
    !prl |-> srq);
endmodule

// File: tb/sim_pio_card_ctrl.sv
module sim_pio_card_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  phase = '0;
  logic [13:0] strobe = '0;
  logic [5:0]  io_sc = '0;
  logic        dma_cyc = 1'b0;
  logic        dev_done = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        skip, prl, irq, srq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [5:0] MY = 6'o12, OTHER = 6'o13;
  localparam logic [4:0] T2 = 5'b00001, T3 = 5'b00010, T4 = 5'b00100,
                         T5 = 5'b01000, T6 = 5'b10000;
  localparam logic [13:0] PON = 14'd1 << 0, PRE = 14'd1 << 1, CRS = 14'd1 << 2,
    ENF = 14'd1 << 3, SIR = 14'd1 << 4, IAK = 14'd1 << 5, STC = 14'd1 << 6,
    CLC = 14'd1 << 7, STF = 14'd1 << 8, CLF = 14'd1 << 9, SFS = 14'd1 << 10,
    SFC = 14'd1 << 11, IOO = 14'd1 << 12, IOI = 14'd1 << 13;

  always #4 clk = ~clk;

  pio_card_ctrl u0 (
    .clk(clk), .rst(rst), .phase(phase), .strobe(strobe), .io_sc(io_sc),
    .dma_cyc(dma_cyc), .dev_done(dev_done), .din(din), .dout(dout),
    .skip(skip), .prl(prl), .irq(irq), .srq(srq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change at the falling edge; combinational outputs are sampled 2 ns later
  task automatic drive(logic [4:0] ph, logic [13:0] st, logic [5:0] sc = MY,
                       logic dma = 0, logic dd = 0, logic [15:0] d = '0);
    @(negedge clk);
    phase = ph; strobe = st; io_sc = sc; dma_cyc = dma; dev_done = dd; din = d;
    #2;
  endtask

  task automatic idle();
    drive(5'b0, '0);
  endtask

  task automatic t_reset();
    idle();
    chk("R1 srq", srq, 0); chk("R1 irq", irq, 0); chk("R1 prl", prl, 1);
    chk("R1 skip", skip, 0); chk("R1 dout", dout, 0);
  endtask

  task automatic t_select();
    drive(T3, STF, OTHER); idle();
    chk("R2 foreign set-flag", srq, 0);
    drive(T3, SFC, OTHER); chk("R2 foreign skip", skip, 0);
    drive(T3, IOO, OTHER, 0, 0, 16'h1111);
    drive(T4, IOI, MY); chk("R2 foreign load", dout, 0);
  endtask

  task automatic t_flag();
    drive(T4, STF); idle(); chk("R4 set-flag wrong phase", srq, 0);
    drive(T3, STF); idle(); chk("R4 set-flag T3", srq, 1);
    drive(T3, CLF); idle(); chk("R4 clear-flag wrong phase", srq, 1);
    drive(T4, CLF); idle(); chk("R4 clear-flag T4", srq, 0);
  endtask

  task automatic t_ctl();
    drive(T3, STF); idle(); chk("R11 prl flag only", prl, 1);
    drive(T3, STC); idle(); chk("R3 set-control T3 cpu ignored", prl, 1);
    drive(T4, STC); idle(); chk("R3 set-control T4", prl, 0);
    chk("R11 srq follows flag", srq, 1);
    drive(T3, CLC, MY, 1); idle(); chk("R3 clear-control T3 dma", prl, 1);
    drive(T3, STC, MY, 1); idle(); chk("R3 set-control T3 dma", prl, 0);
    drive(T4, CLC, MY, 1); idle(); chk("R3 clear-control T4 dma ignored", prl, 0);
    drive(T4, STC | CLC); idle(); chk("R3 clear wins", prl, 1);
    drive(T4, CLF); idle();
  endtask

  task automatic t_skip();
    drive(T3, SFC); chk("R6 sfc flag clear", skip, 1);
    drive(T4, SFS); chk("R6 sfs flag clear", skip, 0);
    drive(T2, SFC); chk("R6 skip outside window T2", skip, 0);
    drive(T6, SFC); chk("R6 skip outside window T6", skip, 0);
    drive(T3, STF); idle();
    drive(T5, SFS); chk("R6 sfs flag set", skip, 1);
    drive(T5, SFC); chk("R6 sfc flag set", skip, 0);
    drive(T4, SFS | CLF); chk("R7 skip before clear", skip, 1);
    idle(); chk("R7 flag cleared after", srq, 0);
    drive(T4, SFS); chk("R7 later test sees clear", skip, 0);
  endtask

  task automatic t_irq();
    drive(T3, STF); drive(T4, STC); idle();
    drive(T5, SIR); idle(); chk("R8 irq all set", irq, 1);
    drive(T6, IAK); idle(); chk("R10 irq kept on ack", irq, 1);
    chk("R10 flag kept on ack", srq, 1);
    drive(T2, ENF); idle(); chk("R9 enable-flag clears irq", irq, 0);
    chk("R5 enable-flag keeps flag", srq, 1);
    drive(T5, SIR); idle(); chk("R8/R10 buffer clear blocks irq", irq, 0);
    drive(T4, CLF); idle();
    drive(T2, ENF); idle(); chk("R5 enable-flag empty buffer", srq, 0);
    drive(T3, '0, MY, 0, 1); idle(); chk("R5 device done buffer only", srq, 0);
    drive(T2, ENF); idle(); chk("R5 enable-flag moves buffer", srq, 1);
    drive(T5, SIR); idle(); chk("R8 irq after device done", irq, 1);
    drive(T2, ENF); idle(); chk("R9 irq dropped", irq, 0);
    drive(T4, STC | CLC); drive(T4, CLF); idle();
  endtask

  task automatic t_preset();
    drive(T3, STF); drive(T4, STC); idle(); chk("R12 setup", prl, 0);
    drive(T2, CRS, OTHER); idle(); chk("R12 control reset", prl, 1);
    chk("R12 control reset keeps flag", srq, 1);
    drive(T4, STC); drive(T5, SIR); idle(); chk("R12 setup irq", irq, 1);
    drive(T5, PRE, OTHER); idle(); chk("R12 preset clears irq", irq, 0);
    drive(T4, CLF); idle();
    drive(T6, PRE | CRS, OTHER); idle(); chk("R12 preset sets flag", srq, 1);
    chk("R12 preset prl", prl, 1);
    drive(T2, ENF); idle(); chk("R12 preset filled buffer", srq, 1);
    drive(T3, IOO, MY, 0, 0, 16'hBEEF);
    drive(T2, PON | PRE | CRS);
    drive(T4, IOI); chk("R12 power-on clears data", dout, 0);
    drive(T4, CLF); idle();
  endtask

  task automatic t_data();
    drive(T3, IOO, MY, 0, 0, 16'hA5A5);
    drive(T4, IOI); chk("R13 read T4", dout, 16'hA5A5);
    drive(T3, IOI); chk("R13 read T3 blocked", dout, 0);
    drive(T5, IOO, MY, 0, 0, 16'h1234);
    drive(T5, IOI); chk("R13 load T5 ignored", dout, 16'hA5A5);
    drive(T4, IOO, MY, 0, 0, 16'h0F0F);
    drive(T5, IOI); chk("R13 load T4", dout, 16'h0F0F);
    idle(); chk("R13 idle bus zero", dout, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_select();
    t_flag();
    t_ctl();
    t_skip();
    t_irq();
    t_preset();
    t_data();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule